// File: doc/BRIEF.md
# Boot Vector Loader

After reset this block brings every hardware thread of a multi-threaded core into a known starting state before any of the threads runs. It walks through the threads in ascending order. For each thread it reads an eight-byte start address from byte memory, one byte per cycle. It assembles that address into the thread's program counter. It also holds the thread's general registers in their cleared state until the thread's vector has arrived.

Thread 0 has a vector slot of its own. Every other thread takes its start address from a table of eight-byte entries, one entry per thread, packed back to back. Each thread gets the same initial stack pointer and a stack bank of its own. The core samples the per-thread outputs and lets the threads run once `done` is high. A fresh reset at any point throws away a partial sequence and starts it again from thread 0.

Top module: `boot_vector_loader`

## Requirements
- R1: While reset is low and on the first edge after its release, `mem_rd` and `done` are 0, every `thread_pc` field is 0 and every `reg_clear` bit is 1.
- R2: Thread 0 reads the bytes at 0xFFC0 through 0xFFC7, lowest address first.
- R3: Thread i, for i of 1 or more, reads the bytes at 0xFF50 + 8*(i-1) through that address + 7, lowest address first.
- R4: The block makes exactly one read per cycle, with no gaps. Threads are read in ascending order. The first read is issued in the cycle that follows the first clock edge after reset release. `mem_rdata` must carry the byte of the request made one cycle earlier.
- R5: Byte b of a thread's vector (b = 0 at the lowest address) becomes bits 8b+7..8b of that thread's 64-bit field in `thread_pc`. Thread t occupies bits 64t+63..64t.
- R6: `done` rises on the clock edge 8*NUM_THREADS+2 after reset release and stays high until the next reset. `mem_rd` is low whenever `done` is high.
- R7: `reg_clear[i]` falls on edge 8*i+10 after reset release and stays low afterwards.
- R8: Every `thread_pc` field reads 0 while `done` is low.
- R9: A reset asserted in the middle of the sequence returns all outputs to the R1 state. After release the sequence restarts from thread 0 and uses the current memory contents.
- R10: Each 16-bit field i of `thread_sp` is 0xFFFF. Each 4-bit field i of `thread_bank` is i+1, with field i at bits 4i+3..4i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | ADDR_W (16) | Byte address of the request |
| mem_rdata | input | 8 | Byte returned one cycle after the request |
| thread_pc | output | 64*NUM_THREADS | Start program counter per thread |
| thread_sp | output | SP_W*NUM_THREADS | Initial stack pointer per thread |
| thread_bank | output | BANK_W*NUM_THREADS | Stack bank per thread |
| reg_clear | output | NUM_THREADS | Hold the thread's general registers at zero |
| done | output | 1 | All threads initialised |

## Verification
Suppose the issue counters slip. The first wrong address then shows on `mem_addr` in the same cycle, because the address is decoded directly from the counter state, and the bench compares it against the computed address on every edge. A fault in capture tagging or byte placement stays hidden until `done`, since the PC fields are masked before then. From that edge onward it appears as a wrong byte lane in one thread's field. A count or termination fault moves the `reg_clear` edge of some thread or the `done` edge by at least one cycle. The bench checks those edges cycle-exactly, across several memory images and after a reset in the middle of a sequence.

// File: rtl/bvl_pkg.sv
package bvl_pkg;

    localparam int VEC_BYTES = 8;
    localparam int OFS_W     = 3;
    localparam int PC_W      = 64;
    localparam int BYTE_W    = 8;

    typedef enum logic [1:0] {
        SEQ_RESET = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_IDLE  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/bvl_addr_gen.sv
module bvl_addr_gen
    import bvl_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter int                TID_W        = 2,
    parameter logic [ADDR_W-1:0] PRIMARY_BASE = 16'hFFC0,
    parameter logic [ADDR_W-1:0] TABLE_BASE   = 16'hFF50
) (
    input  logic [TID_W-1:0]  tid_i,
    input  logic [OFS_W-1:0]  ofs_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [TID_W-1:0]  tbl_idx;
    logic [ADDR_W-1:0] tbl_entry;

    always_comb begin
        tbl_idx   = tid_i - 1'b1;
        tbl_entry = ADDR_W'({tbl_idx, 3'b000});
        if (tid_i == '0) begin
            addr_o = PRIMARY_BASE + ADDR_W'(ofs_i);
        end else begin
            addr_o = TABLE_BASE + tbl_entry + ADDR_W'(ofs_i);
        end
    end

endmodule

// File: rtl/bvl_fetch_seq.sv
module bvl_fetch_seq
    import bvl_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             rd_o,
    output logic [TID_W-1:0] tid_o,
    output logic [OFS_W-1:0] ofs_o
);

    localparam logic [TID_W-1:0] LAST_TID = TID_W'(NUM_THREADS - 1);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(VEC_BYTES - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [TID_W-1:0] tid;
        logic [OFS_W-1:0] ofs;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            SEQ_RESET: begin
                seq_d.state = SEQ_FETCH;
                seq_d.tid   = '0;
                seq_d.ofs   = '0;
            end
            SEQ_FETCH: begin
                seq_d.ofs = seq_q.ofs + 1'b1;
                if (seq_q.ofs == LAST_OFS) begin
                    if (seq_q.tid == LAST_TID) begin
                        seq_d.state = SEQ_IDLE;
                    end else begin
                        seq_d.tid = seq_q.tid + 1'b1;
                    end
                end
            end
            default: begin
                seq_d = seq_q;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: SEQ_RESET, tid: '0, ofs: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rd_o  = (seq_q.state == SEQ_FETCH);
    assign tid_o = seq_q.tid;
    assign ofs_o = seq_q.ofs;

    AST_ISSUE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_o && $past(rd_o)) |->
            ((ofs_o == $past(ofs_o) + 1'b1) &&
             ((ofs_o != '0) ? (tid_o == $past(tid_o)) : (tid_o == $past(tid_o) + 1'b1)))); // R4

    AST_ISSUE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_o |-> (int'(tid_o) < NUM_THREADS)); // R4

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_o && $past(rd_o)) |=> !rd_o); // R6

endmodule

// File: rtl/bvl_capture.sv
module bvl_capture
    import bvl_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rd_i,
    input  logic [TID_W-1:0]            tid_i,
    input  logic [OFS_W-1:0]            ofs_i,
    input  logic [BYTE_W-1:0]           rdata_i,
    output logic [NUM_THREADS*PC_W-1:0] pc_o,
    output logic [NUM_THREADS-1:0]      clear_o,
    output logic                        done_o
);

    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(VEC_BYTES - 1);

    typedef struct packed {
        logic                                vld;
        logic [TID_W-1:0]                    tid;
        logic [OFS_W-1:0]                    ofs;
        logic [NUM_THREADS-1:0]              clr;
        logic                                done;
        logic [NUM_THREADS-1:0][PC_W-1:0]    pc;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = rd_i;
        cap_d.tid = tid_i;
        cap_d.ofs = ofs_i;
        if (cap_q.vld) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                if (cap_q.tid == TID_W'(t)) begin
                    cap_d.pc[t][BYTE_W*int'(cap_q.ofs) +: BYTE_W] = rdata_i;
                    if (cap_q.ofs == LAST_OFS) begin
                        cap_d.clr[t] = 1'b0;
                        if (t == NUM_THREADS - 1) begin
                            cap_d.done = 1'b1;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q     <= '0;
            cap_q.clr <= '1;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign pc_o    = cap_q.pc;
    assign clear_o = cap_q.clr;
    assign done_o  = cap_q.done;

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o); // R6

    AST_CLEAR_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        ((clear_o & ~$past(clear_o)) == '0)); // R7

    AST_CLEAR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_o != $past(clear_o)) |-> $onehot0(clear_o ^ $past(clear_o))); // R7

    AST_DONE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (clear_o == '0)); // R7

endmodule

// File: rtl/boot_vector_loader.sv
module boot_vector_loader
    import bvl_pkg::*;
#(
    parameter int                NUM_THREADS  = 4,
    parameter int                ADDR_W       = 16,
    parameter int                SP_W         = 16,
    parameter int                BANK_W       = 4,
    parameter logic [ADDR_W-1:0] PRIMARY_BASE = 16'hFFC0,
    parameter logic [ADDR_W-1:0] TABLE_BASE   = 16'hFF50,
    parameter logic [SP_W-1:0]   SP_INIT      = 16'hFFFF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    output logic                          mem_rd,
    output logic [ADDR_W-1:0]             mem_addr,
    input  logic [7:0]                    mem_rdata,
    output logic [NUM_THREADS*PC_W-1:0]   thread_pc,
    output logic [NUM_THREADS*SP_W-1:0]   thread_sp,
    output logic [NUM_THREADS*BANK_W-1:0] thread_bank,
    output logic [NUM_THREADS-1:0]        reg_clear,
    output logic                          done
);

    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;

    logic                        iss_rd;
    logic [TID_W-1:0]            iss_tid;
    logic [OFS_W-1:0]            iss_ofs;
    logic [NUM_THREADS*PC_W-1:0] pc_raw;

    bvl_fetch_seq #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W)
    ) i_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_o  (iss_rd),
        .tid_o (iss_tid),
        .ofs_o (iss_ofs)
    );

    bvl_addr_gen #(
        .ADDR_W       (ADDR_W),
        .TID_W        (TID_W),
        .PRIMARY_BASE (PRIMARY_BASE),
        .TABLE_BASE   (TABLE_BASE)
    ) i_addr (
        .tid_i  (iss_tid),
        .ofs_i  (iss_ofs),
        .addr_o (mem_addr)
    );

    bvl_capture #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W)
    ) i_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (iss_rd),
        .tid_i   (iss_tid),
        .ofs_i   (iss_ofs),
        .rdata_i (mem_rdata),
        .pc_o    (pc_raw),
        .clear_o (reg_clear),
        .done_o  (done)
    );

    assign mem_rd = iss_rd;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign thread_pc[t*PC_W +: PC_W]       = done ? pc_raw[t*PC_W +: PC_W] : '0;
        assign thread_sp[t*SP_W +: SP_W]       = SP_INIT;
        assign thread_bank[t*BANK_W +: BANK_W] = BANK_W'(t + 1);
    end

    AST_NO_LATE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !done); // R6

    AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> ((mem_addr[ADDR_W-1:3] == PRIMARY_BASE[ADDR_W-1:3]) ||
                    ((int'(mem_addr) >= int'(TABLE_BASE)) &&
                     (int'(mem_addr) < int'(TABLE_BASE) + 8 * (NUM_THREADS - 1))))); // R3

    AST_FIRST_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |-> (mem_addr == PRIMARY_BASE)); // R2

endmodule

// File: tb/test_boot_vector_loader.sv
module test_boot_vector_loader;

    localparam int  N   = 4;
    localparam time TCK = 10ns;
    localparam int  RUN_EDGES = 8 * N + 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              mem_rd;
    logic [15:0]       mem_addr;
    logic [7:0]        mem_rdata;
    logic [N*64-1:0]   thread_pc;
    logic [N*16-1:0]   thread_sp;
    logic [N*4-1:0]    thread_bank;
    logic [N-1:0]      reg_clear;
    logic              done;

    always #(TCK / 2) clk = ~clk;

    boot_vector_loader #(.NUM_THREADS(N)) i_boot_vector_loader (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_rd      (mem_rd),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata),
        .thread_pc   (thread_pc),
        .thread_sp   (thread_sp),
        .thread_bank (thread_bank),
        .reg_clear   (reg_clear),
        .done        (done)
    );

    // vector patterns; run r gives thread t the entry (r + t) mod 8
    localparam logic [63:0] PATS [8] = '{
        64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
        64'h0000_0000_0000_1000, 64'h8000_0000_0000_0001,
        64'hA5A5_5A5A_C3C3_3C3C, 64'h1111_2222_3333_4444,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000
    };

    logic [7:0] img [256];
    int total = 0;
    int bad   = 0;

    always_ff @(posedge clk) begin
        if (mem_rd) mem_rdata <= img[mem_addr[7:0]];
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_addr(int k);
        int t = k / 8;
        int b = k % 8;
        if (t == 0) return 16'hFFC0 + 16'(b);
        return 16'hFF50 + 16'(8 * (t - 1)) + 16'(b);
    endfunction

    function automatic logic [63:0] exp_pc(int run, int t);
        return PATS[(run + t) % 8];
    endfunction

    task automatic load_img(int run);
        for (int a = 0; a < 256; a++) img[a] = 8'hEE ^ 8'(a);
        for (int t = 0; t < N; t++) begin
            logic [63:0] v = exp_pc(run, t);
            for (int b = 0; b < 8; b++) img[exp_addr(8 * t + b) & 16'h00FF] = v[8*b +: 8];
        end
    endtask

    task automatic check_static();
        for (int t = 0; t < N; t++) begin
            chk(thread_sp[16*t +: 16] == 16'hFFFF, "R10 sp", 64'(thread_sp[16*t +: 16]), 64'hFFFF);
            chk(thread_bank[4*t +: 4] == 4'(t + 1), "R10 bank", 64'(thread_bank[4*t +: 4]), 64'(t + 1));
        end
    endtask

    task automatic check_reset_state(input string tag);
        chk(mem_rd == 1'b0, {tag, " mem_rd"}, 64'(mem_rd), 64'd0);
        chk(done == 1'b0, {tag, " done"}, 64'(done), 64'd0);
        chk(reg_clear == '1, {tag, " reg_clear"}, 64'(reg_clear), 64'(N'('1)));
        chk(thread_pc == '0, {tag, " pc"}, thread_pc[63:0], 64'd0);
        check_static();
    endtask

    // reset, release and check each edge; stops after 'edges' edges
    task automatic run_boot(int run, int edges, input string rst_tag);
        load_img(run);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state(rst_tag);
        @(negedge clk);
        check_reset_state(rst_tag);
        rst_n = 1'b1;
        for (int e = 1; e <= edges; e++) begin
            bit exp_rd;
            bit exp_done;
            @(posedge clk);
            #1;
            exp_rd   = (e <= 8 * N);
            exp_done = (e >= 8 * N + 2);
            if (e == 1) chk(thread_pc == '0 && reg_clear == '1, "R1 first edge", 64'(reg_clear), 64'(N'('1)));
            chk(mem_rd == exp_rd, "R4 read strobe", 64'(mem_rd), 64'(exp_rd));
            if (exp_rd) begin
                chk(mem_addr == exp_addr(e - 1), (e <= 8) ? "R2 address" : "R3 address",
                    64'(mem_addr), 64'(exp_addr(e - 1)));
            end
            chk(done == exp_done, "R6 done", 64'(done), 64'(exp_done));
            for (int t = 0; t < N; t++) begin
                bit exp_clr = (e < 8 * t + 10);
                chk(reg_clear[t] == exp_clr, "R7 reg_clear", 64'(reg_clear[t]), 64'(exp_clr));
                if (exp_done) begin
                    chk(thread_pc[64*t +: 64] == exp_pc(run, t), "R5 pc", thread_pc[64*t +: 64], exp_pc(run, t));
                end else begin
                    chk(thread_pc[64*t +: 64] == '0, "R8 pc hidden", thread_pc[64*t +: 64], 64'd0);
                end
            end
            check_static();
        end
    endtask

    initial begin
        #(TCK * 100000);
        bad++;
        total++;
        $display("FAIL R6 watchdog act=%0d exp=%0d", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        for (int a = 0; a < 256; a++) img[a] = 8'h00;
        // table of patterns walked by one loop
        for (int r = 0; r < 4; r++) run_boot(r, RUN_EDGES, "R1");
        // reset in the middle of thread 1 fetch, then restart with new image
        run_boot(2, 13, "R1");
        run_boot(6, RUN_EDGES, "R9");
        // reset right at the done edge, then restart
        run_boot(5, 8 * N + 2, "R1");
        run_boot(7, RUN_EDGES, "R9");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule